// File: doc/BRIEF.md
# Interrupt Flag Controller for a Timekeeping Device

This block gathers three event sources of a timekeeping device and turns them into one interrupt pin. The sources are a watchdog expiry, an alarm match and a supply-failure warning. Each arrives as a one-cycle pulse from logic outside this block. Every event latches a sticky flag. A per-source enable bit decides whether the event also asserts the pin.

A small host register port gives software two registers. The first is a writable configuration register that holds the three enables, the pin polarity and the pulse/level choice. The second is a read-only flag register, and reading it clears every flag.

The pin is presented as a data/output-enable pair. With active-high polarity the pin is driven push-pull. With active-low polarity it becomes an open-drain pull-down, which is released when not asserted. In pulse mode the pin asserts for a fixed number of clock cycles, and a flag read cuts that short. In level mode the pin holds until the flags are read.

The host port is a plain strobe interface with no back-pressure. A write takes effect on the clock edge of its strobe. Read data appears on the following cycle, together with a one-cycle valid. The host must accept the data in that cycle.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, both registers read 00h and the pin is released (`int_oe`=0, `int_o`=0).
- R2: An event sets its flag in the flag register (address 1: bit0 watchdog, bit1 alarm, bit2 supply-fail) whatever the enables are. The flag is readable from the next cycle.
- R3: A read of address 1 returns the flags and clears all of them, so an immediate second read returns 00h.
- R4: An event whose enable bit is 0 leaves the pin in its released state.
- R5: A write to address 0 stores bits 4:0 (bit0 watchdog enable, bit1 alarm enable, bit2 supply-fail enable, bit3 polarity, bit4 pulse mode). A read of address 0 returns them with bits 7:5 zero. Writes to address 1 leave the flags unchanged.
- R6: With polarity 1, `int_oe` is 1 at all times and `int_o` equals the asserted state.
- R7: With polarity 0, `int_o` is 0 and `int_oe` is 1 exactly while the pin is asserted.
- R8: In level mode (bit4=0), an enabled event asserts the pin from the next cycle until the cycle after a flag read.
- R9: In pulse mode (bit4=1), an enabled event asserts the pin for exactly PULSE_CYCLES cycles, starting on the next cycle.
- R10: In pulse mode, a flag read releases the pin on the cycle after the read.
- R11: An enabled event during a pulse restarts it, giving a further PULSE_CYCLES asserted cycles from the cycle after that event.
- R12: An event in the same cycle as a flag read is not lost. The read returns the flags as they were before the event, the event's flag stays set, and an enabled event keeps the pin asserted.
- R13: Read data is valid in the cycle after the read strobe, with `bus_rvalid_o` high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wdog_evt_i | input | 1 | Watchdog expiry, one-cycle pulse |
| alarm_evt_i | input | 1 | Alarm match, one-cycle pulse |
| pwrfail_evt_i | input | 1 | Supply-failure warning, one-cycle pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (one cycle) |
| bus_addr_i | input | 1 | Register select: 0 configuration, 1 flags |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| int_o | output | 1 | Interrupt pin data |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
The collision that matters is an incoming event and a flag-clearing read landing on the same clock edge. The bench provokes it by raising a read strobe and an event pattern together, sweeping all 64 pairs of pending-flag pattern and colliding-event pattern. It judges each pair on three things: the read must return only the earlier pattern, the following read must return exactly the colliding pattern, and the pin must stay asserted exactly when the colliding pattern hit an enabled source.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned REG_W = 8;

  localparam int unsigned SRC_WDOG  = 0;
  localparam int unsigned SRC_ALARM = 1;
  localparam int unsigned SRC_PWR   = 2;

  // Field order matches the host-visible bit layout of the configuration word.
  typedef struct packed {
    logic            pulse_mode;  // bit4
    logic            act_high;    // bit3
    logic [NSRC-1:0] src_en;      // bits 2:0
  } irq_cfg_t;

  localparam int unsigned CFG_W = $bits(irq_cfg_t);

  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;
endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic bit_q;
    // A same-cycle event wins over the clear, so no event is lost.
    always_ff @(posedge clk_i) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= evt_i[i] | (bit_q & ~clr_i);
    end
    assign flags_o[i] = bit_q;
  end

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  // R3
  rd_clears_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> (flags_o == '0));

  // R12
  collide_keeps_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i != '0) |=> (flags_o == $past(evt_i)));

endmodule

// File: rtl/irq_host_regs.sv
`timescale 1ns/1ps
module irq_host_regs
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NSRC-1:0]  flags_i,
  output irq_cfg_t         cfg_o,
  output logic             flag_clr_o,
  output logic [REG_W-1:0] rdata_o,
  output logic             rvalid_o
);

  irq_cfg_t         cfg_q;
  logic [REG_W-1:0] rdata_q;
  logic             rvalid_q;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_CFG) rd_mux[CFG_W-1:0] = cfg_q;
    else                    rd_mux[NSRC-1:0]  = flags_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == ADDR_CFG) cfg_q <= irq_cfg_t'(wdata_i[CFG_W-1:0]);
      if (rd_i) rdata_q <= rd_mux;
      rvalid_q <= rd_i;
    end
  end

  assign cfg_o      = cfg_q;
  assign flag_clr_o = rd_i && (addr_i == ADDR_FLAG);
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;

  // R13
  rvalid_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  // R13
  rvalid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  // R5
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_CFG) |=> $stable(cfg_q));

endmodule

// File: rtl/irq_pin_drv.sv
`timescale 1ns/1ps
module irq_pin_drv #(
  parameter int unsigned PULSE_CYCLES = 6554,
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  input  logic pulse_mode_i,
  input  logic act_high_i,
  output logic int_o,
  output logic int_oe
);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             active;

  // Both trackers run all the time; the mode bit only picks which one drives.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= fire_i | (lvl_q & ~clr_i);
      if (fire_i)              cnt_q <= CNT_W'(PULSE_CYCLES);
      else if (clr_i)          cnt_q <= '0;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = pulse_mode_i ? (cnt_q != '0) : lvl_q;

  always_comb begin
    if (act_high_i) begin
      int_o  = active;
      int_oe = 1'b1;
    end else begin
      int_o  = 1'b0;
      int_oe = active;
    end
  end

  // R4
  no_fire_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i && $stable(pulse_mode_i)) |=> !$rose(active));

  // R8
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q && !clr_i) |=> lvl_q);

  // R9
  pulse_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PULSE_CYCLES));

  // R10
  clr_ends_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fire_i) |=> (cnt_q == '0));

  // R11
  fire_reloads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cnt_q == CNT_W'(PULSE_CYCLES)));

  // R7
  od_never_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_high_i |-> !int_o);

endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 6554
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdog_evt_i,
  input  logic             alarm_evt_i,
  input  logic             pwrfail_evt_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic             bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output logic             bus_rvalid_o,
  output logic             int_o,
  output logic             int_oe
);

  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] flags;
  irq_cfg_t        cfg;
  logic            flag_clr;
  logic            fire;

  always_comb begin
    evt            = '0;
    evt[SRC_WDOG]  = wdog_evt_i;
    evt[SRC_ALARM] = alarm_evt_i;
    evt[SRC_PWR]   = pwrfail_evt_i;
  end

  assign fire = |(evt & cfg.src_en);

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  irq_host_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .flags_i    (flags),
    .cfg_o      (cfg),
    .flag_clr_o (flag_clr),
    .rdata_o    (bus_rdata_o),
    .rvalid_o   (bus_rvalid_o)
  );

  irq_pin_drv #(.PULSE_CYCLES(PULSE_CYCLES)) u_pin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .clr_i        (flag_clr),
    .pulse_mode_i (cfg.pulse_mode),
    .act_high_i   (cfg.act_high),
    .int_o        (int_o),
    .int_oe       (int_oe)
  );

  // R6
  pp_always_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.act_high |-> int_oe);

endmodule

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
  localparam int unsigned P = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wd = 0, al = 0, pf = 0;
  logic       wr = 0, rd = 0, addr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid, int_o, int_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_flag_ctrl #(.PULSE_CYCLES(P)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wdog_evt_i(wd), .alarm_evt_i(al), .pwrfail_evt_i(pf),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .int_o(int_o), .int_oe(int_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_evt(logic [2:0] e);
    wd = e[0]; al = e[1]; pf = e[2];
  endtask

  task automatic check_pin(string req, bit hl, bit act);
    check(req, {int_o, int_oe}, hl ? {act, 1'b1} : {1'b0, act});
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    cyc();
    wr = 0;
  endtask

  // Any event pattern set beforehand collides with the read strobe.
  task automatic rd_reg(logic a, output logic [7:0] d);
    rd = 1; addr = a;
    cyc();
    rd = 0; set_evt(3'b000);
    check("R13", rvalid, 1);
    d = rdata;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1
    check_pin("R1", 0, 0);
    rd_reg(0, d); check("R1", d, 8'h00);
    rd_reg(1, d); check("R1", d, 8'h00);
    cyc();
    check("R13", rvalid, 0);

    // Sweep every configuration against every event pattern.
    for (int c = 0; c < 32; c++) begin
      for (int p = 1; p < 8; p++) begin
        bit hl, act;
        hl  = c[3];
        act = (p & c & 7) != 0;
        wr_reg(0, 8'(c) | 8'hE0);
        rd_reg(0, d); check("R5", d, 8'(c));
        check_pin("R4", hl, 0);
        set_evt(3'(p)); cyc(); set_evt(3'b000);
        check_pin(act ? (hl ? "R6" : "R7") : "R4", hl, act);
        rd_reg(1, d); check("R2", d, 8'(p));
        check_pin(c[4] ? "R10" : "R8", hl, 0);
        rd_reg(1, d); check("R3", d, 8'h00);
      end
    end

    // Writes to the flag address are ignored.
    wr_reg(0, 8'h00);
    set_evt(3'b010); cyc(); set_evt(3'b000);
    wr_reg(1, 8'hFF);
    rd_reg(1, d); check("R5", d, 8'h02);

    // Level hold over many cycles.
    wr_reg(0, 8'h0F);
    set_evt(3'b100); cyc(); set_evt(3'b000);
    for (int k = 0; k < 3 * P; k++) begin check_pin("R8", 1, 1); cyc(); end
    rd_reg(1, d); check_pin("R8", 1, 0);

    // Pulse width, push-pull then open-drain.
    for (int h = 0; h < 2; h++) begin
      wr_reg(0, h ? 8'h1F : 8'h17);
      set_evt(3'b001); cyc(); set_evt(3'b000);
      for (int k = 0; k < int'(P); k++) begin check_pin("R9", h[0], 1); cyc(); end
      check_pin("R9", h[0], 0);
      rd_reg(1, d); check("R2", d, 8'h01);
    end

    // Restart during a pulse.
    wr_reg(0, 8'h1F);
    set_evt(3'b001); cyc(); set_evt(3'b000);
    cyc(); cyc();
    set_evt(3'b010); cyc(); set_evt(3'b000);
    for (int k = 0; k < int'(P); k++) begin check_pin("R11", 1, 1); cyc(); end
    check_pin("R11", 1, 0);
    rd_reg(1, d); check("R11", d, 8'h03);

    // Read ends the pulse early.
    set_evt(3'b100); cyc(); set_evt(3'b000);
    cyc();
    check_pin("R10", 1, 1);
    rd_reg(1, d); check_pin("R10", 1, 0);
    cyc(); check_pin("R10", 1, 0);

    // Event and read collide on the same edge, level mode, enables 101.
    wr_reg(0, 8'h0D);
    for (int p = 0; p < 8; p++) begin
      for (int e = 0; e < 8; e++) begin
        bit act;
        act = (e & 5) != 0;
        set_evt(3'(p)); cyc();
        set_evt(3'(e));
        rd_reg(1, d); check("R12", d, 8'(p));
        check_pin("R12", 1, act);
        rd_reg(1, d); check("R12", d, 8'(e));
        check_pin("R8", 1, 0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule